// File: doc/BRIEF.md
# Open-Drain Bus Driver with Arbitration Monitor

This block is the pin-facing stage of a master on a two-wire bus that several masters share. The controlling logic gives it the level it wants on the data line and on the clock line. The block turns each wanted level into a pull-low enable and never drives a line high. A wanted 1 releases the line so the external pull-up can raise it. A wanted 0 turns on the low driver.

The block also checks for lost arbitration. On each rising edge of the sampled clock line, it compares the sampled data line with the wanted data bit. It makes this comparison only while it wants the data line high. If the line reads low at that moment, another master is driving it, and this master has lost.

The moment the mismatch is seen, the block releases both lines. It keeps them released until the controlling logic issues a clear. It also records whether the loss happened while an address or a data byte was being sent. A loss in the address phase raises a hint that the local slave logic should keep listening, because this device may be the one being addressed. A loss in the data phase raises a flag that the byte must be sent again later.

Top module: `od_arb_driver`

## Requirements
- R1: After reset, `arb_lost`, `keep_listen` and `resend_req` are 0. With both wanted levels at 1, both pull enables are 0.
- R2: While no loss is held, `sda_pull` equals the inverse of `sda_want`. A wanted 1 releases the line (`sda_pull`=0) and a wanted 0 pulls it low (`sda_pull`=1).
- R3: While no loss is held, `scl_pull` equals the inverse of `scl_want`, with the same release/pull rule as the data line.
- R4: A mismatch is a cycle in which three things are true: `scl_in` is 1 and was 0 in the previous cycle, `sda_want` is 1, and `sda_in` is 0. `sda_in` low while `sda_want` is 0 never counts as a mismatch. `sda_in` low while `scl_in` stays high also never counts as a mismatch.
- R5: In the cycle a mismatch is present, both `sda_pull` and `scl_pull` are 0 without waiting for a clock edge. `arb_lost` is 1 from the next clock edge.
- R6: Once `arb_lost` is 1, it stays 1 until `clear` is sampled high, and both pull enables stay 0 whatever the wanted levels are. After the clear, the pull enables follow the wanted levels again.
- R7: `phase_data` is 0 for the address phase and 1 for the data phase, and it is sampled with the mismatch. A loss in the address phase gives `keep_listen`=1 and `resend_req`=0. A loss in the data phase gives `resend_req`=1 and `keep_listen`=0. Both flags are 0 while no loss is held.
- R8: A `clear` that coincides with a new mismatch leaves `arb_lost` at 1 and records the phase of the new mismatch. A `clear` with no loss held changes nothing.
- R9: While a loss is held and no `clear` is given, a later mismatch does not change the recorded phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sda_want | input | 1 | Data bit the master wants on the line |
| scl_want | input | 1 | Clock level the master wants on the line |
| phase_data | input | 1 | 0 = address phase, 1 = data phase |
| sda_in | input | 1 | Sampled data line |
| scl_in | input | 1 | Sampled clock line |
| clear | input | 1 | Drops a held loss |
| sda_pull | output | 1 | Pull-low enable for the data line |
| scl_pull | output | 1 | Pull-low enable for the clock line |
| arb_lost | output | 1 | Arbitration loss held |
| keep_listen | output | 1 | Loss happened in the address phase |
| resend_req | output | 1 | Loss happened in the data phase |

## Verification
Two functions can land in the same cycle: the detection of a new mismatch and the software clear of a loss that is already held. The bench first holds a data-phase loss. It then raises `clear` in the very cycle it produces a clock rising edge with data wanted high and sampled low, this time in the address phase. The result is judged after the clock edge. `arb_lost` must still be 1, and the phase flags must have switched to the address-phase pattern. That switch shows that the new mismatch, not the clear, decided the outcome.

// File: rtl/od_arb_pkg.sv
package od_arb_pkg;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_e;

  // pull-low enable for one line: only a wanted 0 pulls, a hold releases
  function automatic logic pull_en(input logic want, input logic hold);
    return ~want & ~hold;
  endfunction

  // arbitration mismatch: high wanted, low observed
  function automatic logic mismatch(input logic want, input logic seen);
    return want & ~seen;
  endfunction
endpackage

// File: rtl/od_arb_edge.sv
module od_arb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  logic line_q;

  // idle bus reads high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_in;
  end

  assign rise = line_in & ~line_q;
endmodule

// File: rtl/od_arb_monitor.sv
module od_arb_monitor
  import od_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   evt,
  input  logic   clear,
  input  phase_e phase_in,
  output logic   lost_q,
  output phase_e phase_q
);
  logic take_new;
  assign take_new = evt & (~lost_q | clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q  <= 1'b0;
      phase_q <= PH_ADDR;
    end else if (take_new) begin
      lost_q  <= 1'b1;
      phase_q <= phase_in;
    end else if (clear) begin
      lost_q  <= 1'b0;
    end
  end

  // R6
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q && !clear |=> lost_q);
  // R9
  phase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q && !clear |=> $stable(phase_q));
  // R8
  clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear && evt |=> lost_q && phase_q == $past(phase_in));
endmodule

// File: rtl/od_arb_drive.sv
module od_arb_drive
  import od_arb_pkg::*;
(
  input  logic sda_want,
  input  logic scl_want,
  input  logic hold,
  output logic sda_pull,
  output logic scl_pull
);
  assign sda_pull = pull_en(sda_want, hold);
  assign scl_pull = pull_en(scl_want, hold);
endmodule

// File: rtl/od_arb_driver.sv
module od_arb_driver
  import od_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sda_want,
  input  logic scl_want,
  input  logic phase_data,
  input  logic sda_in,
  input  logic scl_in,
  input  logic clear,
  output logic sda_pull,
  output logic scl_pull,
  output logic arb_lost,
  output logic keep_listen,
  output logic resend_req
);
  logic   scl_rise;
  logic   arb_evt;
  logic   lost_q;
  logic   hold;
  phase_e phase_q;
  phase_e phase_in;

  assign phase_in = phase_data ? PH_DATA : PH_ADDR;

  od_arb_edge u_edge (
    .clk(clk), .rst_n(rst_n), .line_in(scl_in), .rise(scl_rise)
  );

  assign arb_evt = scl_rise & mismatch(sda_want, sda_in);

  od_arb_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .evt(arb_evt), .clear(clear),
    .phase_in(phase_in), .lost_q(lost_q), .phase_q(phase_q)
  );

  // release in the detecting cycle as well as while held
  assign hold = lost_q | arb_evt;

  od_arb_drive u_drv (
    .sda_want(sda_want), .scl_want(scl_want), .hold(hold),
    .sda_pull(sda_pull), .scl_pull(scl_pull)
  );

  assign arb_lost    = lost_q;
  assign keep_listen = lost_q & (phase_q == PH_ADDR);
  assign resend_req  = lost_q & (phase_q == PH_DATA);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q || arb_evt) |-> !sda_pull && !scl_pull);
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({keep_listen, resend_req}) == (arb_lost ? 1 : 0));
  // R4
  low_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_lost && !sda_want |=> !arb_lost);
endmodule

// File: tb/sim_od_arb_driver.sv
module sim_od_arb_driver;
  logic clk = 0, rst_n = 0;
  logic sda_want = 1, scl_want = 1, phase_data = 0;
  logic sda_in = 1, scl_in = 1, clear = 0;
  logic sda_pull, scl_pull, arb_lost, keep_listen, resend_req;
  int   n_run = 0, n_fail = 0;
  logic done = 0;

  always #4 clk = ~clk;

  od_arb_driver u0 (
    .clk(clk), .rst_n(rst_n), .sda_want(sda_want), .scl_want(scl_want),
    .phase_data(phase_data), .sda_in(sda_in), .scl_in(scl_in), .clear(clear),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .arb_lost(arb_lost),
    .keep_listen(keep_listen), .resend_req(resend_req)
  );

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (sda_pull scl_pull lost keep resend)", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {sda_pull, scl_pull, arb_lost, keep_listen, resend_req};
  endfunction

  // inputs change just after the falling edge
  task automatic setin(logic sw, logic cw, logic ph, logic si, logic ci, logic cl);
    sda_want = sw; scl_want = cw; phase_data = ph;
    sda_in = si; scl_in = ci; clear = cl;
    #1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", outs(), 5'b00000);
  endtask

  task automatic t_drive();
    setin(0, 1, 0, 0, 1, 0); check("R2", outs(), 5'b10000);
    setin(1, 0, 0, 1, 1, 0); check("R3", outs(), 5'b01000);
    setin(0, 0, 0, 0, 1, 0); check("R2", outs(), 5'b11000);
    step();
  endtask

  task automatic t_nocheck();
    setin(0, 0, 0, 0, 0, 0); step();
    setin(0, 1, 0, 0, 1, 0); step();          // rise, low wanted, low seen
    check("R4", outs(), 5'b10000);
    setin(1, 1, 0, 0, 1, 0); step();          // low seen, no rise
    check("R4", outs(), 5'b00000);
    setin(1, 0, 0, 1, 0, 0); step();
    setin(1, 1, 0, 1, 1, 0); step();          // rise, high seen
    check("R4", outs(), 5'b00000);
  endtask

  // scl low one cycle, then rising edge with mismatch
  task automatic make_loss(logic ph, logic cl);
    setin(1, 0, ph, 1, 0, 0); step();
    setin(1, 0, ph, 0, 1, cl);
  endtask

  task automatic t_addr_loss();
    make_loss(0, 0);
    check("R5", outs(), 5'b00000);            // scl_want 0 yet released
    step();
    check("R7", outs(), 5'b00110);
    setin(0, 0, 1, 0, 1, 0); step(); step();
    check("R6", outs(), 5'b00110);
    make_loss(1, 0); step();
    check("R9", outs(), 5'b00110);
    setin(0, 0, 0, 0, 1, 1); step();
    setin(0, 0, 0, 0, 1, 0);
    check("R6", outs(), 5'b11000);
  endtask

  task automatic t_data_loss();
    make_loss(1, 0); step();
    check("R7", outs(), 5'b00101);
  endtask

  task automatic t_collide();
    make_loss(0, 1); step();                  // clear with new address-phase loss
    check("R8", outs(), 5'b00110);
    setin(1, 1, 0, 1, 1, 1); step();
    setin(1, 1, 0, 1, 1, 1); step();          // clear while not lost
    setin(0, 1, 0, 0, 1, 0);
    check("R8", outs(), 5'b10000);
  endtask

  initial begin
    setin(1, 1, 0, 1, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_drive();
    t_nocheck();
    t_addr_loss();
    t_data_loss();
    t_collide();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule